// File: doc/BRIEF.md
# Interlocked Read Handshake Memory Responder

This block is the memory side of a fully interlocked, four-phase read exchange on a shared data bus. It runs on its own clock and treats the requester's request and acknowledge lines as asynchronous, so it passes both through two-flop synchronizers. When a request appears, it latches the address that the requester is driving on the shared lines and raises its own acknowledge. It keeps that acknowledge up until the requester withdraws the request, which also releases the shared lines. Only then does it drive the addressed word and raise data-ready, after a configurable number of extra cycles.

The requester takes the word and raises its acknowledge. The responder then drops data-ready and turns off its bus driver. It returns to idle only once the requester's acknowledge has gone low again, so a new request cannot be mistaken for the end of the old one.

Storage is a small register array. It is loaded with a computed pattern at reset and has no write path. An address past the end of the array reads as all ones. The latency is taken from an input when the address is captured.

The controller has six states:
- IDLE: waits for the synchronized request.
- CAPT: latches the address and the latency.
- ACK: acknowledge is high.
- WAIT: counts latency cycles.
- DRIVE: the data-ready phase, with the bus driven.
- CLOSE: waits for the requester's acknowledge to fall.

The transitions are:
- IDLE→CAPT on the synchronized request.
- CAPT→ACK unconditionally.
- ACK→DRIVE when the request drops and the latency is zero.
- ACK→WAIT when the request drops and the latency is non-zero.
- WAIT→DRIVE when the count expires.
- DRIVE→CLOSE on the requester's acknowledge.
- CLOSE→IDLE when that acknowledge falls.

Top module: `hsk_mem_responder`

## Requirements
- R1: After reset, `ack_o`, `data_rdy_o` and `bus_oe_o` are low and `bus_o` is zero.
- R2: With `rd_req_i` raised before rising edge k, `ack_o` is still low after edge k+2 and high after edge k+3.
- R3: `ack_o` stays high while the request is held. After `rd_req_i` falls before edge j, `ack_o` goes low after edge j+2.
- R4: `data_rdy_o` and `bus_oe_o` never rise while `ack_o` is high, and the two are never high together with `ack_o`.
- R5: With latency L on `lat_i` at capture, `data_rdy_o` rises exactly L cycles after the edge on which `ack_o` falls. For L=0 both change on the same edge.
- R6: For an address a below DEPTH (12), `bus_o` carries ((a*16'h0101) mod 2^16) XOR 16'hC3A5, stable for the whole data-ready phase.
- R7: An address of DEPTH or above returns 16'hFFFF.
- R8: `data_rdy_o` holds until `ack_i` rises. After `ack_i` rises before edge m, `data_rdy_o` and `bus_oe_o` are low after edge m+2.
- R9: While `ack_i` is still high after the data phase, a new request is not acknowledged. It is acknowledged only after `ack_i` falls.
- R10: Changes on `bus_i` after the address is captured do not affect the returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Responder clock |
| rst_n | input | 1 | Active-low reset |
| rd_req_i | input | 1 | Asynchronous read request from the requester |
| ack_i | input | 1 | Asynchronous acknowledge from the requester |
| lat_i | input | LW | Extra cycles before data-ready, latched at capture |
| bus_i | input | DW | Value seen on the shared data lines |
| bus_o | output | DW | Word driven onto the shared lines |
| bus_oe_o | output | 1 | Tri-state enable for `bus_o` |
| ack_o | output | 1 | Responder acknowledge |
| data_rdy_o | output | 1 | Read data valid on the bus |

## Verification
Two events can land on the same clock edge: the acknowledge release and the data-ready rise. This happens when the latency is zero, because the ACK→DRIVE transition drops `ack_o` and raises `data_rdy_o` at once. The latency sweep provokes this case with L=0 for both an in-range and an out-of-range address. The check samples at the falling edge just after `ack_o` drops and expects `data_rdy_o` already high with zero gap cycles, while the exclusion property confirms the two are never high together. The non-zero sweep points show the gap growing one cycle per unit of L.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPT,
        ST_ACK,
        ST_WAIT,
        ST_DRIVE,
        ST_CLOSE
    } rsp_state_e;

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end
        assign sync_o[b] = stab_q;
    end

endmodule

// File: rtl/hsk_store.sv
module hsk_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] addr_i,
    output logic [DW-1:0] word_o
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] cell_q [DEPTH];
    logic          in_range;
    logic [IW-1:0] idx;

    function automatic logic [DW-1:0] seed_word(input int i);
        logic [31:0] prod;
        prod = i * 257;
        return DW'(prod) ^ DW'(32'h0000_C3A5);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= seed_word(i);
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= cell_q[i];
            end
        end
    end

    assign in_range = (addr_i < DW'(DEPTH));
    assign idx      = addr_i[IW-1:0];

    always_comb begin
        if (in_range) begin
            word_o = cell_q[idx];
        end else begin
            word_o = '1;
        end
    end

endmodule

// File: rtl/hsk_lat_cnt.sv
module hsk_lat_cnt #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [LW-1:0] load_val_i,
    input  logic          dec_i,
    output logic          zero_o,
    output logic          one_o
);

    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - LW'(1);
        end
    end

    assign zero_o = (cnt_q == '0);
    assign one_o  = (cnt_q == LW'(1));

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q != '0)); // R5

endmodule

// File: rtl/hsk_mem_responder.sv
module hsk_mem_responder
    import hsk_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 12,
    parameter int LW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req_i,
    input  logic          ack_i,
    input  logic [LW-1:0] lat_i,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] bus_o,
    output logic          bus_oe_o,
    output logic          ack_o,
    output logic          data_rdy_o
);

    localparam int NSYNC = 2;

    rsp_state_e     state_q;
    rsp_state_e     state_nx;
    logic [NSYNC-1:0] sync_raw;
    logic [NSYNC-1:0] sync_out;
    logic           req_s;
    logic           peer_ack_s;
    logic [DW-1:0]  addr_q;
    logic [DW-1:0]  rd_word;
    logic           cnt_load;
    logic           cnt_dec;
    logic           cnt_zero;
    logic           cnt_one;

    assign sync_raw   = {ack_i, rd_req_i};
    assign req_s      = sync_out[0];
    assign peer_ack_s = sync_out[1];

    hsk_sync #(.W(NSYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sync_raw),
        .sync_o  (sync_out)
    );

    hsk_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr_q),
        .word_o (rd_word)
    );

    hsk_lat_cnt #(.LW(LW)) u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (lat_i),
        .dec_i      (cnt_dec),
        .zero_o     (cnt_zero),
        .one_o      (cnt_one)
    );

    // next-state decode
    always_comb begin
        state_nx = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_s) state_nx = ST_CAPT;
            end
            ST_CAPT: begin
                cnt_load = 1'b1;
                state_nx = ST_ACK;
            end
            ST_ACK: begin
                if (!req_s) state_nx = cnt_zero ? ST_DRIVE : ST_WAIT;
            end
            ST_WAIT: begin
                cnt_dec = 1'b1;
                if (cnt_one) state_nx = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (peer_ack_s) state_nx = ST_CLOSE;
            end
            ST_CLOSE: begin
                if (!peer_ack_s) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // address capture, one cycle after the synchronized request is seen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (state_q == ST_CAPT) begin
            addr_q <= bus_i;
        end
    end

    // registered outputs, glitch-free toward the asynchronous requester
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o      <= 1'b0;
            data_rdy_o <= 1'b0;
            bus_oe_o   <= 1'b0;
            bus_o      <= '0;
        end else begin
            ack_o      <= (state_nx == ST_ACK);
            data_rdy_o <= (state_nx == ST_DRIVE);
            bus_oe_o   <= (state_nx == ST_DRIVE);
            bus_o      <= (state_nx == ST_DRIVE) ? rd_word : '0;
        end
    end

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && req_s) |=> ack_o); // R3

    AST_RDY_NOT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rdy_o) |-> !ack_o); // R4

    AST_OE_NOT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> !ack_o); // R4

    AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy_o && !peer_ack_s) |=> data_rdy_o); // R8

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy_o && $past(data_rdy_o)) |-> $stable(bus_o)); // R6

    AST_NO_REACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLOSE && peer_ack_s) |=> !ack_o); // R9

endmodule

// File: tb/hsk_mem_responder_tb.sv
module hsk_mem_responder_tb_top;

    localparam int DW    = 16;
    localparam int DEPTH = 12;
    localparam int LW    = 4;
    localparam int NVEC  = 8;

    // each entry: {address[15:0], latency[3:0]}
    localparam logic [19:0] VEC [NVEC] = '{
        {16'h0000, 4'd0},
        {16'h0001, 4'd1},
        {16'h0005, 4'd3},
        {16'h000B, 4'd0},
        {16'h000C, 4'd2},
        {16'h00FF, 4'd0},
        {16'h0007, 4'd5},
        {16'h0003, 4'd15}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req_i = 1'b0;
    logic          ack_i = 1'b0;
    logic [LW-1:0] lat_i = '0;
    logic [DW-1:0] bus_i = '0;
    logic [DW-1:0] bus_o;
    logic          bus_oe_o;
    logic          ack_o;
    logic          data_rdy_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    hsk_mem_responder #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req_i   (rd_req_i),
        .ack_i      (ack_i),
        .lat_i      (lat_i),
        .bus_i      (bus_i),
        .bus_o      (bus_o),
        .bus_oe_o   (bus_oe_o),
        .ack_o      (ack_o),
        .data_rdy_o (data_rdy_o)
    );

    function automatic logic [15:0] exp_word(input logic [15:0] a);
        logic [15:0] p;
        p = a * 16'h0101;
        return (a < 16'(DEPTH)) ? (p ^ 16'hC3A5) : 16'hFFFF;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // full read exchange with measurements at every phase
    task automatic do_read(input logic [15:0] a, input logic [3:0] l);
        int n;
        lat_i    = l;
        bus_i    = a;
        rd_req_i = 1'b1;
        n = 0;
        while (!ack_o && n < 40) begin tick(); n++; end
        chk(n == 4, "R2 cycles to ack", 32'(n), 32'd4);
        bus_i = ~a; // R10: lines move after capture
        repeat (3) tick();
        chk(ack_o == 1'b1, "R3 ack held", 32'(ack_o), 32'd1);
        rd_req_i = 1'b0;
        bus_i    = 16'hDEAD;
        n = 0;
        while (ack_o && n < 40) begin tick(); n++; end
        chk(n == 3, "R3 cycles to ack drop", 32'(n), 32'd3);
        n = 0;
        while (!data_rdy_o && n < 40) begin tick(); n++; end
        chk(n == int'(l), "R5 gap ack-fall to data-ready", 32'(n), 32'(l));
        chk(bus_oe_o && bus_o == exp_word(a),
            (a < 16'(DEPTH)) ? "R6 R10 word" : "R7 out-of-range word",
            {15'd0, bus_oe_o, bus_o}, {16'd1, exp_word(a)});
        repeat (2) tick();
        chk(data_rdy_o == 1'b1, "R8 data-ready held", 32'(data_rdy_o), 32'd1);
        ack_i = 1'b1;
        n = 0;
        while (data_rdy_o && n < 40) begin tick(); n++; end
        chk(n == 3 && !bus_oe_o, "R8 release", 32'(n), 32'd3);
        ack_i = 1'b0;
        repeat (4) tick();
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(!ack_o && !data_rdy_o && !bus_oe_o && bus_o == '0, "R1 reset state",
            {29'd0, ack_o, data_rdy_o, bus_oe_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) tick();

        for (int v = 0; v < NVEC; v++) begin
            do_read(VEC[v][19:4], VEC[v][3:0]);
        end

        // R9: new request while the requester's acknowledge is still high
        lat_i = 4'd0; bus_i = 16'h0002; rd_req_i = 1'b1;
        n = 0; while (!ack_o && n < 40) begin tick(); n++; end
        rd_req_i = 1'b0;
        n = 0; while (!data_rdy_o && n < 40) begin tick(); n++; end
        ack_i = 1'b1;
        n = 0; while (data_rdy_o && n < 40) begin tick(); n++; end
        bus_i = 16'h0004; rd_req_i = 1'b1;
        repeat (10) tick();
        chk(ack_o == 1'b0, "R9 no ack while peer ack high", 32'(ack_o), 32'd0);
        ack_i = 1'b0;
        n = 0; while (!ack_o && n < 40) begin tick(); n++; end
        chk(ack_o == 1'b1, "R9 ack after peer ack falls", 32'(ack_o), 32'd1);
        rd_req_i = 1'b0;
        n = 0; while (!data_rdy_o && n < 40) begin tick(); n++; end
        chk(bus_o == exp_word(16'h0004), "R6 word after R9 exchange", 32'(bus_o), 32'(exp_word(16'h0004)));
        ack_i = 1'b1;
        n = 0; while (data_rdy_o && n < 40) begin tick(); n++; end
        ack_i = 1'b0;
        repeat (4) tick();

        // R4: data-ready never coincides with ack during a zero-latency read
        bus_i = 16'h0009; lat_i = 4'd0; rd_req_i = 1'b1;
        n = 0; while (!ack_o && n < 40) begin tick(); n++; end
        rd_req_i = 1'b0;
        n = 0;
        while (ack_o && n < 40) begin
            chk(!data_rdy_o && !bus_oe_o, "R4 no data while ack", {30'd0, data_rdy_o, bus_oe_o}, 32'd0);
            tick(); n++;
        end
        chk(data_rdy_o, "R5 zero latency same edge", 32'(data_rdy_o), 32'd1);
        ack_i = 1'b1;
        n = 0; while (data_rdy_o && n < 40) begin tick(); n++; end
        ack_i = 1'b0;
        repeat (4) tick();

        // R1: reset in mid-exchange returns outputs to rest
        bus_i = 16'h0001; rd_req_i = 1'b1;
        n = 0; while (!ack_o && n < 40) begin tick(); n++; end
        rst_n = 1'b0;
        rd_req_i = 1'b0;
        tick();
        chk(!ack_o && !data_rdy_o && !bus_oe_o, "R1 reset mid-exchange",
            {29'd0, ack_o, data_rdy_o, bus_oe_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule